// File: doc/BRIEF.md
# Selectable Wrap/Saturate Adder-Subtractor

This block is a purely combinational signed arithmetic unit. It takes two two's complement operands of a parameterised width (4 bits by default). A 2-bit operation select picks one of four results: a wrapping sum, a wrapping difference, a clamped sum or a clamped difference. One shared adder serves all four operations. Subtraction is formed inside the block by adding the bitwise inverse of the second operand with a carry-in of one, so the block needs no pre-inverted copy of that operand.

In the wrapping operations the result is taken modulo 2^W. In the clamped operations, a result that does not fit is replaced by the nearest representable extreme: the largest positive value or the most negative value. An overflow flag reports, in every operation, whether the true signed result lies outside the representable range. The unit is meant to sit between registers of a surrounding datapath, with both results available in the same cycle as its operands.

Top module: `satwrap_addsub`

## Requirements
- R1: With select 2'b00, `sum_o` equals `lhs_i + rhs_i` modulo 2^W, even when the true sum is out of range (W=4: 7+1 gives 4'b1000).
- R2: With select 2'b01, `sum_o` equals `lhs_i - rhs_i` modulo 2^W, even when the true difference is out of range (W=4: -8-1 gives 4'b0111).
- R3: With select 2'b10 or 2'b11, a true result above the largest positive value gives `sum_o` = 0 followed by W-1 ones (W=4: 4'b0111).
- R4: With select 2'b10 or 2'b11, a true result below the most negative value gives `sum_o` = 1 followed by W-1 zeros (W=4: 4'b1000).
- R5: With select 2'b10 or 2'b11, a true result that fits in W signed bits, including exactly the two extremes, appears on `sum_o` unchanged.
- R6: With select 2'b11, subtracting the most negative value (4'b1000) is handled correctly: 0-(-8) clamps to 4'b0111, and -1-(-8) gives 4'b0111 with no overflow.
- R7: `ovf_o` is 1 exactly when the true signed result of the selected addition or subtraction lies outside [-2^(W-1), 2^(W-1)-1], in all four operations.
- R8: Both outputs follow any change of the inputs without a clock edge; several input changes within one clock period each produce their own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs_i | input | W | First operand, two's complement |
| rhs_i | input | W | Second operand, two's complement |
| op_sel_i | input | 2 | Bit 1 selects clamping, bit 0 selects subtraction |
| sum_o | output | W | Selected result |
| ovf_o | output | 1 | True result outside the signed range |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages between the inputs and either output. The bench therefore changes inputs on the falling clock edge and samples both outputs one nanosecond later, well before the next rising edge. No check waits for a clock. For R8, the bench changes the operands twice inside one clock period and checks each settled value before the next change.

// File: rtl/satwrap_addsub_pkg.sv
package satwrap_addsub_pkg;

    // Bit 1: clamp on overflow, bit 0: subtract
    typedef enum logic [1:0] {
        OP_WRAP_ADD = 2'b00,
        OP_WRAP_SUB = 2'b01,
        OP_SAT_ADD  = 2'b10,
        OP_SAT_SUB  = 2'b11
    } op_sel_e;

    function automatic logic op_is_sub(input op_sel_e op);
        return (op == OP_WRAP_SUB) || (op == OP_SAT_SUB);
    endfunction

    function automatic logic op_is_sat(input op_sel_e op);
        return (op == OP_SAT_ADD) || (op == OP_SAT_SUB);
    endfunction

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep #(
    parameter int W = 4
) (
    input  logic [W-1:0] rhs_i,
    input  logic         sub_i,
    output logic [W-1:0] rhs_eff_o,
    output logic         carry_in_o
);

    // Subtraction: add the inverted operand plus one
    always_comb begin
        rhs_eff_o  = sub_i ? ~rhs_i : rhs_i;
        carry_in_o = sub_i;
    end

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int W = 4
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_eff_i,
    input  logic         carry_in_i,
    output logic [W-1:0] raw_sum_o,
    output logic         ovf_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] cin_ext_d;

    always_comb begin
        cin_ext_d = {{(W-1){1'b0}}, carry_in_i};
        raw_sum_o = lhs_i + rhs_eff_i + cin_ext_d;
        // Like-signed inputs producing an opposite-signed sum
        ovf_o     = (lhs_i[MSB] == rhs_eff_i[MSB]) && (raw_sum_o[MSB] != lhs_i[MSB]);
    end

endmodule

// File: rtl/addsub_clamp.sv
module addsub_clamp #(
    parameter int W = 4
) (
    input  logic [W-1:0] raw_sum_i,
    input  logic         ovf_i,
    input  logic         lhs_sign_i,
    input  logic         sat_en_i,
    output logic [W-1:0] sum_o
);

    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (sat_en_i && ovf_i) begin
            // Overflow direction follows the sign of the first operand
            sum_o = lhs_sign_i ? NEG_LIMIT : POS_LIMIT;
        end else begin
            sum_o = raw_sum_i;
        end
    end

endmodule

// File: rtl/satwrap_addsub.sv
module satwrap_addsub
    import satwrap_addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic [1:0]   op_sel_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);

    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] POS_MAX = (XW'(1) <<< (W-1)) - XW'(1);
    localparam logic signed [XW-1:0] NEG_MIN = -(XW'(1) <<< (W-1));

    op_sel_e      op_d;
    logic         sub_d;
    logic         sat_d;
    logic [W-1:0] rhs_eff_d;
    logic         cin_d;
    logic [W-1:0] raw_d;
    logic         ovf_d;

    always_comb begin
        op_d  = op_sel_e'(op_sel_i);
        sub_d = op_is_sub(op_d);
        sat_d = op_is_sat(op_d);
    end

    addsub_operand_prep #(.W(W)) u_prep (
        .rhs_i      (rhs_i),
        .sub_i      (sub_d),
        .rhs_eff_o  (rhs_eff_d),
        .carry_in_o (cin_d)
    );

    addsub_core #(.W(W)) u_core (
        .lhs_i      (lhs_i),
        .rhs_eff_i  (rhs_eff_d),
        .carry_in_i (cin_d),
        .raw_sum_o  (raw_d),
        .ovf_o      (ovf_d)
    );

    addsub_clamp #(.W(W)) u_clamp (
        .raw_sum_i  (raw_d),
        .ovf_i      (ovf_d),
        .lhs_sign_i (lhs_i[W-1]),
        .sat_en_i   (sat_d),
        .sum_o      (sum_o)
    );

    assign ovf_o = ovf_d;

    // Independent wide-precision model for the deferred checks
    logic signed [XW-1:0] exact_d;

    always_comb begin
        logic signed [XW-1:0] l_ext;
        logic signed [XW-1:0] r_ext;
        l_ext   = {{2{lhs_i[W-1]}}, lhs_i};
        r_ext   = {{2{rhs_i[W-1]}}, rhs_i};
        exact_d = op_sel_i[0] ? (l_ext - r_ext) : (l_ext + r_ext);

        // R1 R2
        wrap_result_chk: assert final (op_sel_i[1] || sum_o == exact_d[W-1:0])
            else $error("wrap result mismatch");
        // R7
        overflow_flag_chk: assert final (ovf_o == ((exact_d > POS_MAX) || (exact_d < NEG_MIN)))
            else $error("overflow flag mismatch");
        // R3
        clamp_high_chk: assert final (!(op_sel_i[1] && exact_d > POS_MAX) || sum_o == POS_MAX[W-1:0])
            else $error("positive clamp mismatch");
        // R4
        clamp_low_chk: assert final (!(op_sel_i[1] && exact_d < NEG_MIN) || sum_o == NEG_MIN[W-1:0])
            else $error("negative clamp mismatch");
        // R5
        no_overflow_chk: assert final (!(op_sel_i[1] && !ovf_o) || sum_o == exact_d[W-1:0])
            else $error("in-range pass-through mismatch");
    end

endmodule

// File: tb/satwrap_addsub_bench.sv
module satwrap_addsub_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    logic [1:0]   op_sel;
    logic [W-1:0] sum;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    satwrap_addsub #(.W(W)) u_satwrap_addsub (
        .lhs_i    (lhs),
        .rhs_i    (rhs),
        .op_sel_i (op_sel),
        .sum_o    (sum),
        .ovf_o    (ovf)
    );

    // Fields: op(2) lhs(4) rhs(4) expected sum(4) expected ovf(1)
    localparam int NV = 15;
    localparam logic [14:0] VECS [NV] = '{
        {2'b00, 4'h3, 4'h2, 4'h5, 1'b0},  // R1
        {2'b00, 4'h7, 4'h1, 4'h8, 1'b1},  // R1 R7
        {2'b00, 4'h8, 4'hF, 4'h7, 1'b1},  // R1 R7
        {2'b01, 4'h5, 4'h3, 4'h2, 1'b0},  // R2
        {2'b01, 4'h8, 4'h1, 4'h7, 1'b1},  // R2 R7
        {2'b01, 4'h0, 4'h8, 4'h8, 1'b1},  // R2 R7
        {2'b10, 4'h7, 4'h1, 4'h7, 1'b1},  // R3
        {2'b10, 4'h8, 4'hF, 4'h8, 1'b1},  // R4
        {2'b10, 4'hF, 4'hD, 4'hC, 1'b0},  // R5
        {2'b11, 4'h0, 4'h8, 4'h7, 1'b1},  // R6 R3
        {2'b11, 4'h8, 4'h1, 4'h8, 1'b1},  // R4
        {2'b11, 4'h2, 4'h5, 4'hD, 1'b0},  // R5
        {2'b10, 4'h4, 4'h3, 4'h7, 1'b0},  // R5 upper edge
        {2'b11, 4'h9, 4'h1, 4'h8, 1'b0},  // R5 lower edge
        {2'b11, 4'hF, 4'h8, 4'h7, 1'b0}   // R6 R5
    };

    function automatic string req_of(input logic [1:0] op, input logic ov, input logic [W-1:0] res);
        if (op == 2'b00) return "R1";
        if (op == 2'b01) return "R2";
        if (!ov)         return "R5";
        if (!res[W-1])   return "R3";
        return "R4";
    endfunction

    task automatic check_sum(input string req, input logic [W-1:0] exp_v);
        checks++;
        if (sum !== exp_v) begin
            errors++;
            $display("FAIL %s op=%b lhs=%h rhs=%h sum actual=%h expected=%h", req, op_sel, lhs, rhs, sum, exp_v);
        end
    endtask

    task automatic check_ovf(input logic exp_v);
        checks++;
        if (ovf !== exp_v) begin
            errors++;
            $display("FAIL R7 op=%b lhs=%h rhs=%h ovf actual=%b expected=%b", op_sel, lhs, rhs, ovf, exp_v);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_sel = op;
        lhs    = a;
        rhs    = b;
        #1;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        lhs    = '0;
        rhs    = '0;
        op_sel = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        // Quiet inputs during reset: zero result, no overflow
        check_sum("R1", 4'h0);
        check_ovf(1'b0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][14:13], VECS[i][12:9], VECS[i][8:5]);
            check_sum(req_of(VECS[i][14:13], VECS[i][0], VECS[i][4:1]), VECS[i][4:1]);
            check_ovf(VECS[i][0]);
        end

        // R8: two changes within one clock period, no edge in between
        @(negedge clk);
        op_sel = 2'b10; lhs = 4'h6; rhs = 4'h5;
        #1;
        check_sum("R8", 4'h7);
        lhs = 4'h1; rhs = 4'h2;
        #1;
        check_sum("R8", 4'h3);
        op_sel = 2'b01;
        #1;
        check_sum("R8", 4'hF);

        // R6: subtract most negative value across all first operands
        for (int a = -8; a < 8; a++) begin
            int ex;
            apply(2'b11, 4'(a), 4'h8);
            ex = a + 8;
            check_sum("R6", (ex > 7) ? 4'h7 : 4'(ex));
        end

        // Exhaustive sweep against integer arithmetic
        for (int op = 0; op < 4; op++) begin
            for (int a = -8; a < 8; a++) begin
                for (int b = -8; b < 8; b++) begin
                    int ex;
                    logic ov;
                    logic [W-1:0] exp_s;
                    ex = (op % 2 == 1) ? (a - b) : (a + b);
                    ov = (ex > 7) || (ex < -8);
                    if (op >= 2 && ex > 7)       exp_s = 4'h7;
                    else if (op >= 2 && ex < -8) exp_s = 4'h8;
                    else                         exp_s = 4'(ex);
                    apply(2'(op), 4'(a), 4'(b));
                    check_sum(req_of(2'(op), ov, exp_s), exp_s);
                    check_ovf(ov);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule